// File: doc/BRIEF.md
# Register Dependency Scoreboard with Forwarding

This block keeps, for every architectural register of an in-order pipeline, an ordered list of the sequence numbers of the instructions that will still write it. Registers come in three classes, integer, floating-point and miscellaneous. Each class has its own index space, and each register in it has its own fixed-depth writer queue. Issue logic appends a writer when an instruction with that destination enters the pipeline. Completion or squash logic takes writers out again, either by searching the list or by popping its head. An execute notification marks a writer's result as produced.

Four lookups run every cycle, all combinational from the current queue state. A read check and a write check tell a requester whether it may touch the register file. A forward query names the older writer, if there is one, whose result can be bypassed this cycle. The allocate path is a valid/ready interface. `alloc_ready` reflects only whether the targeted queue has room, and it never depends on `alloc_valid`. A producer may hold `alloc_valid` high with stable fields until ready is seen, and a transfer happens on a clock edge where both are high. All other pins are plain control and status.

Top module: `reg_dep_scoreboard`

## Requirements
- R1: The class field selects the index space: 0 is integer, 1 is floating-point, 2 is miscellaneous. Each (class, index) pair has its own queue, so activity on one class never affects the same index in another. Class 3, and any index beyond the size of its class, is untracked: checks pass, forwarding reports no source, and allocate and release have no effect.
- R2: An accepted allocate appends its sequence number at the tail of the target queue, which keeps program order. The queue shows the change from the next clock edge.
- R3: Integer register 0 is never tracked. An allocate to it is accepted and changes nothing. A release to it never raises `rel_err`. Checks on it always pass, and it never forwards.
- R4: `rd_ok` is high when the register's queue is empty, or when `rd_seq` is less than or equal to the sequence number at the head of the queue. Otherwise it is low.
- R5: `wr_ok` follows the same rule on its own independent query port.
- R6: A forward query takes the last queue entry, counted from the head, whose sequence number is strictly less than `fw_seq`. `fw_hit` is high only if that entry was marked executed on an earlier clock edge. A mark given in the current cycle does not count. `fw_src_seq` carries that entry's sequence number on a hit and 0 otherwise.
- R7: A search release (`rel_front`=0) removes the matching entry from any position, and the remaining entries keep their order. If no entry matches, `rel_err` is high in that cycle and the queue is unchanged.
- R8: A front release (`rel_front`=1) removes the head only if the head equals `rel_seq`. A mismatch or an empty queue raises `rel_err` in that cycle and leaves the queue unchanged.
- R9: `alloc_ready` is low when the target queue holds DEPTH entries. While it is low, nothing is appended, even if a release to the same queue occurs in that cycle.
- R10: A release and an allocate in the same cycle are both applied, release first. The new writer lands after the entries that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties all queues |
| alloc_valid | input | 1 | Allocate request valid |
| alloc_ready | output | 1 | Target queue can accept a writer |
| alloc_cls | input | 2 | Allocate register class |
| alloc_idx | input | IDX_W | Allocate register index |
| alloc_seq | input | SEQ_W | Sequence number of the writer |
| rel_valid | input | 1 | Release request |
| rel_front | input | 1 | 1 pops the head, 0 searches the queue |
| rel_cls | input | 2 | Release register class |
| rel_idx | input | IDX_W | Release register index |
| rel_seq | input | SEQ_W | Sequence number to remove |
| rel_err | output | 1 | Release found no matching entry |
| exec_valid | input | 1 | Writer has produced its result |
| exec_cls | input | 2 | Executed writer register class |
| exec_idx | input | IDX_W | Executed writer register index |
| exec_seq | input | SEQ_W | Executed writer sequence number |
| rd_cls | input | 2 | Read check class |
| rd_idx | input | IDX_W | Read check index |
| rd_seq | input | SEQ_W | Read requester sequence number |
| rd_ok | output | 1 | Read permitted |
| wr_cls | input | 2 | Write check class |
| wr_idx | input | IDX_W | Write check index |
| wr_seq | input | SEQ_W | Write requester sequence number |
| wr_ok | output | 1 | Write permitted |
| fw_cls | input | 2 | Forward query class |
| fw_idx | input | IDX_W | Forward query index |
| fw_seq | input | SEQ_W | Forward requester sequence number |
| fw_hit | output | 1 | An older executed writer can supply the value |
| fw_src_seq | output | SEQ_W | Sequence number of the supplying writer |

## Verification
`rd_ok`, `wr_ok`, `fw_hit`, `fw_src_seq`, `alloc_ready` and `rel_err` are due in the same cycle as the inputs that pose the question. The effect of an allocate, a release or an execute mark is due from the cycle after the clock edge that takes it. A mark therefore makes its writer forwardable one cycle later, never in its own cycle. The driver changes inputs only on the falling edge and queues the expected values for that cycle. The monitor compares them one time unit later, so queries about new state are always posed after the committing rising edge.

// File: rtl/rdsb_pkg.sv
package rdsb_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2,
    CLS_NONE = 2'd3
  } reg_class_e;
endpackage

// File: rtl/rdsb_regmap.sv
module rdsb_regmap #(
  parameter int INT_REGS  = 16,
  parameter int FP_REGS   = 16,
  parameter int MISC_REGS = 8,
  parameter int IDX_W     = 4,
  parameter int FLAT_W    = 6
) (
  input  logic [1:0]        cls,
  input  logic [IDX_W-1:0]  idx,
  output logic [FLAT_W-1:0] flat,
  output logic              trk
);
  import rdsb_pkg::*;

  always_comb begin
    flat = '0;
    trk  = 1'b0;
    unique case (reg_class_e'(cls))
      CLS_INT: begin
        trk  = (idx != '0) && (32'(idx) < INT_REGS);
        flat = FLAT_W'(idx);
      end
      CLS_FP: begin
        trk  = 32'(idx) < FP_REGS;
        flat = FLAT_W'(idx) + FLAT_W'(INT_REGS);
      end
      CLS_MISC: begin
        trk  = 32'(idx) < MISC_REGS;
        flat = FLAT_W'(idx) + FLAT_W'(INT_REGS + FP_REGS);
      end
      default: begin
        trk  = 1'b0;
        flat = '0;
      end
    endcase
  end
endmodule

// File: rtl/rdsb_queue.sv
module rdsb_queue #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_en,
  input  logic [SEQ_W-1:0]            push_seq,
  input  logic                        rel_en,
  input  logic                        rel_front,
  input  logic [SEQ_W-1:0]            rel_seq,
  input  logic                        mark_en,
  input  logic [SEQ_W-1:0]            mark_seq,
  output logic [DEPTH-1:0][SEQ_W-1:0] seq_o,
  output logic [DEPTH-1:0]            rdy_o,
  output logic [CNT_W-1:0]            cnt_o,
  output logic                        hit_o
);
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q, seq_n;
  logic [DEPTH-1:0]            rdy_q, rdy_n;
  logic [CNT_W-1:0]            cnt_q, cnt_n, cnt_rm, pos;
  logic [DEPTH:0][SEQ_W-1:0]   seq_x;
  logic [DEPTH:0]              rdy_x;
  logic                        hit, rm;

  // locate the entry a release refers to
  always_comb begin
    hit = 1'b0;
    pos = '0;
    if (rel_front) begin
      hit = (cnt_q != '0) && (seq_q[0] == rel_seq);
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!hit && (CNT_W'(i) < cnt_q) && (seq_q[i] == rel_seq)) begin
          hit = 1'b1;
          pos = CNT_W'(i);
        end
      end
    end
  end

  assign rm = rel_en && hit;

  // mark, then remove, then append at the new tail
  always_comb begin
    seq_x = '0;
    rdy_x = '0;
    for (int i = 0; i < DEPTH; i++) begin
      seq_x[i] = seq_q[i];
      rdy_x[i] = rdy_q[i] |
                 (mark_en && (CNT_W'(i) < cnt_q) && (seq_q[i] == mark_seq));
    end
    cnt_rm = cnt_q - CNT_W'(rm);
    for (int i = 0; i < DEPTH; i++) begin
      if (rm && (CNT_W'(i) >= pos)) begin
        seq_n[i] = seq_x[i+1];
        rdy_n[i] = rdy_x[i+1];
      end else begin
        seq_n[i] = seq_x[i];
        rdy_n[i] = rdy_x[i];
      end
      if (push_en && (CNT_W'(i) == cnt_rm)) begin
        seq_n[i] = push_seq;
        rdy_n[i] = 1'b0;
      end
    end
    cnt_n = cnt_rm + CNT_W'(push_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= '0;
      rdy_q <= '0;
      cnt_q <= '0;
    end else begin
      seq_q <= seq_n;
      rdy_q <= rdy_n;
      cnt_q <= cnt_n;
    end
  end

  assign seq_o = seq_q;
  assign rdy_o = rdy_q;
  assign cnt_o = cnt_q;
  assign hit_o = hit;

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_front_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en && rel_front && hit |=>
      cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1) + CNT_W'($past(push_en))));

  assert_miss_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en && !hit && !push_en |=> cnt_q == $past(cnt_q));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && !rel_en |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/rdsb_check.sv
module rdsb_check #(
  parameter int SEQ_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             trk,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic [SEQ_W-1:0] req_seq,
  output logic             ok
);
  assign ok = !trk || (cnt == '0) || (req_seq <= head_seq);
endmodule

// File: rtl/rdsb_fwd_pick.sv
module rdsb_fwd_pick #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 3
) (
  input  logic                        trk,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
  input  logic [DEPTH-1:0]            rdy,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [SEQ_W-1:0]            req_seq,
  output logic                        hit,
  output logic [SEQ_W-1:0]            src_seq
);
  logic             found, sel_rdy;
  logic [SEQ_W-1:0] sel_seq;

  // last older writer scanning from the head
  always_comb begin
    found   = 1'b0;
    sel_rdy = 1'b0;
    sel_seq = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < cnt) && (seq[i] < req_seq)) begin
        found   = 1'b1;
        sel_seq = seq[i];
        sel_rdy = rdy[i];
      end
    end
  end

  assign hit     = trk && found && sel_rdy;
  assign src_seq = hit ? sel_seq : '0;
endmodule

// File: rtl/reg_dep_scoreboard.sv
module reg_dep_scoreboard #(
  parameter int INT_REGS  = 16,
  parameter int FP_REGS   = 16,
  parameter int MISC_REGS = 8,
  parameter int DEPTH     = 4,
  parameter int SEQ_W     = 8,
  localparam int MAX_A    = (INT_REGS > FP_REGS) ? INT_REGS : FP_REGS,
  localparam int MAX_REGS = (MAX_A > MISC_REGS) ? MAX_A : MISC_REGS,
  localparam int IDX_W    = $clog2(MAX_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [1:0]       alloc_cls,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic             rel_valid,
  input  logic             rel_front,
  input  logic [1:0]       rel_cls,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic [SEQ_W-1:0] rel_seq,
  output logic             rel_err,
  input  logic             exec_valid,
  input  logic [1:0]       exec_cls,
  input  logic [IDX_W-1:0] exec_idx,
  input  logic [SEQ_W-1:0] exec_seq,
  input  logic [1:0]       rd_cls,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [SEQ_W-1:0] rd_seq,
  output logic             rd_ok,
  input  logic [1:0]       wr_cls,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEQ_W-1:0] wr_seq,
  output logic             wr_ok,
  input  logic [1:0]       fw_cls,
  input  logic [IDX_W-1:0] fw_idx,
  input  logic [SEQ_W-1:0] fw_seq,
  output logic             fw_hit,
  output logic [SEQ_W-1:0] fw_src_seq
);
  localparam int NREG   = INT_REGS + FP_REGS + MISC_REGS;
  localparam int FLAT_W = $clog2(NREG);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [FLAT_W-1:0] a_flat, r_flat, e_flat, rd_flat, wr_flat, f_flat;
  logic              a_trk, r_trk, e_trk, rd_trk, wr_trk, f_trk;

  logic [DEPTH-1:0][SEQ_W-1:0] q_seq [NREG];
  logic [DEPTH-1:0]            q_rdy [NREG];
  logic [CNT_W-1:0]            q_cnt [NREG];
  logic [NREG-1:0]             q_hit;
  logic                        alloc_full, alloc_fire;

  rdsb_regmap #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .MISC_REGS(MISC_REGS),
                .IDX_W(IDX_W), .FLAT_W(FLAT_W))
    u_map_alloc (.cls(alloc_cls), .idx(alloc_idx), .flat(a_flat), .trk(a_trk));
  rdsb_regmap #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .MISC_REGS(MISC_REGS),
                .IDX_W(IDX_W), .FLAT_W(FLAT_W))
    u_map_rel (.cls(rel_cls), .idx(rel_idx), .flat(r_flat), .trk(r_trk));
  rdsb_regmap #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .MISC_REGS(MISC_REGS),
                .IDX_W(IDX_W), .FLAT_W(FLAT_W))
    u_map_exec (.cls(exec_cls), .idx(exec_idx), .flat(e_flat), .trk(e_trk));
  rdsb_regmap #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .MISC_REGS(MISC_REGS),
                .IDX_W(IDX_W), .FLAT_W(FLAT_W))
    u_map_rd (.cls(rd_cls), .idx(rd_idx), .flat(rd_flat), .trk(rd_trk));
  rdsb_regmap #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .MISC_REGS(MISC_REGS),
                .IDX_W(IDX_W), .FLAT_W(FLAT_W))
    u_map_wr (.cls(wr_cls), .idx(wr_idx), .flat(wr_flat), .trk(wr_trk));
  rdsb_regmap #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .MISC_REGS(MISC_REGS),
                .IDX_W(IDX_W), .FLAT_W(FLAT_W))
    u_map_fw (.cls(fw_cls), .idx(fw_idx), .flat(f_flat), .trk(f_trk));

  assign alloc_full  = q_cnt[a_flat] == CNT_W'(DEPTH);
  assign alloc_ready = !a_trk || !alloc_full;
  assign alloc_fire  = alloc_valid && alloc_ready && a_trk;
  assign rel_err     = rel_valid && r_trk && !q_hit[r_flat];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    rdsb_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (alloc_fire && (a_flat == FLAT_W'(r))),
      .push_seq (alloc_seq),
      .rel_en   (rel_valid && r_trk && (r_flat == FLAT_W'(r))),
      .rel_front(rel_front),
      .rel_seq  (rel_seq),
      .mark_en  (exec_valid && e_trk && (e_flat == FLAT_W'(r))),
      .mark_seq (exec_seq),
      .seq_o    (q_seq[r]),
      .rdy_o    (q_rdy[r]),
      .cnt_o    (q_cnt[r]),
      .hit_o    (q_hit[r])
    );
  end

  rdsb_check #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_rd_chk (
    .trk(rd_trk), .cnt(q_cnt[rd_flat]), .head_seq(q_seq[rd_flat][0]),
    .req_seq(rd_seq), .ok(rd_ok));

  rdsb_check #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_wr_chk (
    .trk(wr_trk), .cnt(q_cnt[wr_flat]), .head_seq(q_seq[wr_flat][0]),
    .req_seq(wr_seq), .ok(wr_ok));

  rdsb_fwd_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_fwd (
    .trk(f_trk), .seq(q_seq[f_flat]), .rdy(q_rdy[f_flat]), .cnt(q_cnt[f_flat]),
    .req_seq(fw_seq), .hit(fw_hit), .src_seq(fw_src_seq));

  assert_zero_reg_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt[0] == '0);

  assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_ready && !rel_valid |=>
      q_cnt[$past(a_flat)] == $past(q_cnt[a_flat]));

  assert_fwd_older_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fw_hit |-> fw_src_seq < fw_seq);

  assert_rd_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt[rd_flat] == '0) |-> rd_ok);
endmodule

// File: tb/reg_dep_scoreboard_tb.sv
module reg_dep_scoreboard_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string tag;
    int    sel;
    int    val;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 0, rel_valid = 0, rel_front = 0, exec_valid = 0;
  logic [1:0] alloc_cls = 0, rel_cls = 0, exec_cls = 0, rd_cls = 0, wr_cls = 0, fw_cls = 0;
  logic [3:0] alloc_idx = 0, rel_idx = 0, exec_idx = 0, rd_idx = 0, wr_idx = 0, fw_idx = 0;
  logic [7:0] alloc_seq = 0, rel_seq = 0, exec_seq = 0, rd_seq = 0, wr_seq = 0, fw_seq = 0;
  logic       alloc_ready, rel_err, rd_ok, wr_ok, fw_hit;
  logic [7:0] fw_src_seq;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_dep_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_cls(alloc_cls),
    .alloc_idx(alloc_idx), .alloc_seq(alloc_seq),
    .rel_valid(rel_valid), .rel_front(rel_front), .rel_cls(rel_cls),
    .rel_idx(rel_idx), .rel_seq(rel_seq), .rel_err(rel_err),
    .exec_valid(exec_valid), .exec_cls(exec_cls), .exec_idx(exec_idx), .exec_seq(exec_seq),
    .rd_cls(rd_cls), .rd_idx(rd_idx), .rd_seq(rd_seq), .rd_ok(rd_ok),
    .wr_cls(wr_cls), .wr_idx(wr_idx), .wr_seq(wr_seq), .wr_ok(wr_ok),
    .fw_cls(fw_cls), .fw_idx(fw_idx), .fw_seq(fw_seq), .fw_hit(fw_hit),
    .fw_src_seq(fw_src_seq)
  );

  // sel: 0 rd_ok, 1 wr_ok, 2 fw_hit, 3 fw_src_seq, 4 alloc_ready, 5 rel_err
  task automatic expect_v(input string tag, input int sel, input int val);
    exp_t e;
    e.tag = tag; e.sel = sel; e.val = val;
    exp_q.push_back(e);
  endtask

  function automatic int observe(input int sel);
    case (sel)
      0: return int'(rd_ok);
      1: return int'(wr_ok);
      2: return int'(fw_hit);
      3: return int'(fw_src_seq);
      4: return int'(alloc_ready);
      default: return int'(rel_err);
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() != 0) begin
        exp_t e;
        int   got;
        e = exp_q.pop_front();
        got = observe(e.sel);
        n_checks++;
        if (got != e.val) begin
          n_fail++;
          $display("FAIL %s: sel %0d actual %0d expected %0d", e.tag, e.sel, got, e.val);
        end
      end
    end
  end

  task automatic clr();
    alloc_valid = 0; rel_valid = 0; exec_valid = 0; rel_front = 0;
  endtask

  task automatic op_idle();
    @(negedge clk); clr();
  endtask

  task automatic op_alloc(input int c, input int i, input int s);
    @(negedge clk); clr();
    alloc_valid = 1; alloc_cls = 2'(c); alloc_idx = 4'(i); alloc_seq = 8'(s);
  endtask

  task automatic op_rel(input bit front, input int c, input int i, input int s);
    @(negedge clk); clr();
    rel_valid = 1; rel_front = front; rel_cls = 2'(c); rel_idx = 4'(i); rel_seq = 8'(s);
  endtask

  task automatic op_exec(input int c, input int i, input int s);
    @(negedge clk); clr();
    exec_valid = 1; exec_cls = 2'(c); exec_idx = 4'(i); exec_seq = 8'(s);
  endtask

  task automatic probe(input int c, input int i, input int s);
    rd_cls = 2'(c); rd_idx = 4'(i); rd_seq = 8'(s);
    wr_cls = 2'(c); wr_idx = 4'(i); wr_seq = 8'(s);
    fw_cls = 2'(c); fw_idx = 4'(i); fw_seq = 8'(s);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state
    op_idle(); probe(0, 5, 10);
    expect_v("R4 reset rd", 0, 1); expect_v("R5 reset wr", 1, 1);
    expect_v("R6 reset fw", 2, 0); expect_v("R9 reset ready", 4, 1);

    // R2 program order and R1 class separation
    op_alloc(0, 5, 10); op_alloc(0, 5, 12); op_alloc(1, 5, 11);
    op_idle(); probe(0, 5, 10); expect_v("R4 equal head", 0, 1);
    op_idle(); probe(0, 5, 11);
    expect_v("R4 younger stalls", 0, 0); expect_v("R5 younger stalls", 1, 0);
    op_idle(); probe(1, 5, 11); expect_v("R1 fp own queue", 0, 1);
    op_idle(); probe(1, 5, 12); expect_v("R1 fp younger", 0, 0);

    // R6 forwarding timing
    op_exec(0, 5, 12); probe(0, 5, 13); expect_v("R6 same cycle mark", 2, 0);
    op_idle(); expect_v("R6 marked earlier", 2, 1); expect_v("R6 src", 3, 12);
    op_idle(); probe(0, 5, 11); expect_v("R6 older not executed", 2, 0);
    op_idle(); probe(0, 5, 10); expect_v("R6 none older", 2, 0);
    expect_v("R6 src zero", 3, 0);

    // R3 zero register
    op_alloc(0, 0, 20); expect_v("R3 zero accepted", 4, 1);
    op_idle(); probe(0, 0, 25);
    expect_v("R3 zero rd", 0, 1); expect_v("R3 zero fw", 2, 0);
    op_rel(0, 0, 0, 99); expect_v("R3 zero release", 5, 0);

    // R1 misc class and untracked class
    op_alloc(2, 3, 50);
    op_idle(); probe(2, 3, 51); expect_v("R1 misc stalls", 0, 0);
    op_idle(); probe(0, 3, 51); expect_v("R1 int same idx", 0, 1);
    op_idle(); probe(3, 3, 51); expect_v("R1 class 3", 0, 1);

    // R7 search release, R8 front release
    op_alloc(0, 5, 14);
    op_rel(0, 0, 5, 12); expect_v("R7 search hit", 5, 0);
    op_rel(1, 0, 5, 10); expect_v("R8 front hit", 5, 0);
    op_idle(); probe(0, 5, 14); expect_v("R7 head now 14", 0, 1);
    op_idle(); probe(0, 5, 15);
    expect_v("R7 head 14 stalls", 0, 0); expect_v("R7 removed 12 no fw", 2, 0);
    op_rel(0, 0, 5, 12); expect_v("R7 miss", 5, 1);
    op_rel(1, 0, 5, 99); expect_v("R8 mismatch", 5, 1);
    op_idle(); expect_v("R8 unchanged", 0, 0);
    op_rel(1, 2, 4, 1); expect_v("R8 empty", 5, 1);

    // R9 full queue
    op_alloc(0, 7, 30); op_alloc(0, 7, 31); op_alloc(0, 7, 32); op_alloc(0, 7, 33);
    op_alloc(0, 7, 34); expect_v("R9 full not ready", 4, 0);
    op_idle(); probe(0, 7, 31); expect_v("R9 head 30", 1, 0);
    op_rel(1, 0, 7, 30); expect_v("R9 pop head", 5, 0);
    op_idle(); expect_v("R9 head 31", 1, 1);
    op_rel(0, 0, 7, 34); expect_v("R9 34 never added", 5, 1);
    op_alloc(0, 7, 35); expect_v("R9 room again", 4, 1);

    // R10 release and allocate together
    op_alloc(0, 9, 40); op_alloc(0, 9, 42);
    op_alloc(0, 9, 44); rel_valid = 1; rel_front = 0; rel_cls = 0; rel_idx = 4'd9; rel_seq = 8'd40;
    expect_v("R10 release ok", 5, 0); expect_v("R10 alloc ready", 4, 1);
    op_rel(1, 0, 9, 42); expect_v("R10 head 42", 5, 0);
    op_idle(); probe(0, 9, 43); expect_v("R10 head 44", 0, 1);
    op_idle(); probe(0, 9, 45); expect_v("R10 head 44 stalls", 0, 0);

    op_idle(); op_idle(); op_idle();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule